// File: doc/BRIEF.md
# Per-Pin Input Glitch and Debounce Filter

This block sits between the synchronizer outputs of a GPIO bank and the logic that consumes pin levels, such as the interrupt detector. Each pin can be left unfiltered, so its output is the synchronized input with no extra delay. It can also be given a filter. A filtered pin runs in one of two modes. The short mode rejects any pulse that lasts only one system clock. The long mode samples the pin on a slow tick and rejects any pulse that does not survive two consecutive ticks.

All pins in the long mode share one tick generator. It fires every 2*(D+1) system clocks, where D is a programmable divider value. Writing a new divider value restarts the count. Per-pin configuration uses bit masks: one mask turns filters on and another turns them off, and one mask selects the long mode while another selects the short mode. Bits that are zero in a mask leave their pins unchanged. A driver that enables the short filter writes the mode first and then the enable. For the long filter the order is mode, then divider, then enable.

Top module: `pin_filter_bank`

## Requirements
- R1: After reset every pin is unfiltered, every pin is in short (glitch) mode and the divider value is 0.
- R2: An unfiltered pin drives `pin_out` equal to `pin_in` combinationally, in the same cycle, with no register in the path.
- R3: A one-bit in `flt_on` enables the pin's filter at the next edge, and a one-bit in `flt_off` disables it. When both bits are set in the same cycle, disable wins. Pins whose bits are zero in both masks keep their state.
- R4: A one-bit in `sel_long` selects long (debounce) mode and a one-bit in `sel_short` selects short (glitch) mode, at the next edge. When both bits are set, short mode wins. Pins whose bits are zero keep their mode.
- R5: In short mode, a change of the input reaches the output at the second rising edge after the change. A pulse lasting one clock never reaches the output, and a pulse of two or more clocks does.
- R6: A divider write at edge W takes effect at that edge and restarts the tick, which then falls on edges W+P, W+2P, and so on, with P = 2*(D+1).
- R7: In long mode, the output takes a new input value at the second tick edge that sees it. A pulse held for fewer than 2P clocks right after a divider write is rejected, and a pulse of 2P clocks passes.
- R8: A divider write uses only the low DIV_W bits of `div_wdata`. Higher bits are ignored.
- R9: Enabling a filter on a pin whose input has been steady causes no change at that pin's output, because a disabled filter keeps tracking its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Synchronized pin levels |
| flt_on | input | NPINS | Mask: enable filter on pins with a one |
| flt_off | input | NPINS | Mask: disable filter on pins with a one |
| sel_long | input | NPINS | Mask: choose debounce mode |
| sel_short | input | NPINS | Mask: choose glitch mode |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | CFG_W | Divider write data, low DIV_W bits used |
| pin_out | output | NPINS | Filtered pin levels |

## Verification
The assertions assume that `pin_in` is already synchronized, so it changes at most once per system clock and is stable around each edge. They also assume that the configuration masks and the divider strobe are single-cycle pulses that are sampled at the edge. The stimulus changes every input 2 ns after a rising edge and samples outputs at that same point, before driving anything new. The stimulus also keeps all filtered pins at a steady low level while it changes the configuration. Every timing-sensitive sequence starts with a divider write, so the bench knows the tick phase exactly without looking inside the design.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Filter mode held per pin: glitch rejection on the system clock, or
  // debounce on the shared divided tick.
  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } pf_mode_e;
endpackage

// File: rtl/pf_cfg_regs.sv
module pf_cfg_regs #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] flt_on,
  input  logic [NPINS-1:0] flt_off,
  input  logic [NPINS-1:0] sel_long,
  input  logic [NPINS-1:0] sel_short,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] long_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      long_q <= '0;
    end else begin
      en_q   <= (en_q | flt_on) & ~flt_off;      // disable wins
      long_q <= (long_q | sel_long) & ~sel_short; // short mode wins
    end
  end

  p_off_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (flt_off != '0) |=> ((en_q & $past(flt_off)) == '0));

  p_short_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_short != '0) |=> ((long_q & $past(sel_short)) == '0));
endmodule

// File: rtl/pf_tick_gen.sv
module pf_tick_gen #(
  parameter int DIV_W = 8,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_we,
  input  logic [CFG_W-1:0] div_wdata,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  // Last count of the period is 2*D+1, i.e. the divider shifted left with a one.
  assign tick = (cnt_q == {div_q, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (div_we) begin
      div_q <= div_wdata[DIV_W-1:0];
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    div_we |=> !tick);

  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pf_pin_cell.sv
module pf_pin_cell
  import pf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  input  logic     en,
  input  pf_mode_e mode,
  input  logic     tick,
  output logic     dout
);
  logic smp_q;
  logic flt_q;
  logic take;

  // Glitch mode samples every clock, debounce mode only on the shared tick.
  assign take = (mode == MODE_SHORT) || tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (!en) begin
      smp_q <= din;
      flt_q <= din;
    end else if (take) begin
      smp_q <= din;
      if (din == smp_q) flt_q <= din;
    end
  end

  assign dout = en ? flt_q : din;

  p_glitch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_SHORT && din != smp_q) |=> $stable(flt_q));

  p_debounce_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_LONG && !tick) |=> $stable(flt_q));
endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank
  import pf_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DIV_W = 14,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] flt_on,
  input  logic [NPINS-1:0] flt_off,
  input  logic [NPINS-1:0] sel_long,
  input  logic [NPINS-1:0] sel_short,
  input  logic             div_we,
  input  logic [CFG_W-1:0] div_wdata,
  output logic [NPINS-1:0] pin_out
);
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] long_q;
  logic             tick;

  pf_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .flt_on    (flt_on),
    .flt_off   (flt_off),
    .sel_long  (sel_long),
    .sel_short (sel_short),
    .en_q      (en_q),
    .long_q    (long_q)
  );

  pf_tick_gen #(.DIV_W(DIV_W), .CFG_W(CFG_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .tick      (tick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pf_pin_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_in[i]),
      .en   (en_q[i]),
      .mode (pf_mode_e'(long_q[i])),
      .tick (tick),
      .dout (pin_out[i])
    );
  end

  p_reset_clean_r1: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && long_q == '0));
endmodule

// File: tb/sim_pin_filter_bank.sv
`timescale 1ns/1ps
module sim_pin_filter_bank;
  localparam int NP = 8;
  localparam int DW = 4;
  localparam int CW = 8;
  localparam logic [NP-1:0] DISM = 8'h03;
  localparam logic [NP-1:0] GLM  = 8'h0C;
  localparam logic [NP-1:0] DBM  = 8'hF0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0, flt_on = '0, flt_off = '0, sel_long = '0, sel_short = '0;
  logic          div_we = 1'b0;
  logic [CW-1:0] div_wdata = '0;
  logic [NP-1:0] pin_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_filter_bank #(.NPINS(NP), .DIV_W(DW), .CFG_W(CW)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .flt_on(flt_on), .flt_off(flt_off),
    .sel_long(sel_long), .sel_short(sel_short), .div_we(div_we),
    .div_wdata(div_wdata), .pin_out(pin_out)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_div(input logic [CW-1:0] v);
    div_we = 1'b1; div_wdata = v;
    cyc(1);
    div_we = 1'b0; div_wdata = '0;
  endtask

  // R6/R7: hold a high level right after a divider write; P = 2*(d+1).
  task automatic hold_test(input logic [CW-1:0] wv, input int d);
    int p = 2 * (d + 1);
    cyc(3);
    wr_div(wv);
    pin_in = '1;
    #1 chk("R2 same-cycle pass", pin_out, DISM);
    cyc(1); chk("R5 glitch edge1", pin_out, DISM);
    cyc(1); chk("R5 glitch edge2", pin_out, DISM | GLM);
    cyc(2 * p - 3); chk("R7 before 2nd tick (R6)", pin_out, DISM | GLM);
    cyc(1); chk("R7 at 2nd tick (R6)", pin_out, '1);
    pin_in = '0;
    cyc(2 * p + 2); chk("R7 return low", pin_out, '0);
  endtask

  // R5/R7: pulse of w clocks after a divider write.
  task automatic pulse_test(input int d, input int w);
    int p = 2 * (d + 1);
    logic [NP-1:0] acc = '0, exp;
    cyc(2);
    wr_div(CW'(d));
    pin_in = '1;
    for (int k = 0; k < w; k++) begin cyc(1); acc |= pin_out; end
    pin_in = '0;
    for (int k = 0; k < 2 * p + 2; k++) begin cyc(1); acc |= pin_out; end
    exp = DISM | ((w >= 2) ? GLM : '0) | ((w >= 2 * p) ? DBM : '0);
    chk($sformatf("R5/R7 pulse d=%0d w=%0d", d, w), acc, exp);
    chk("R7 idle after pulse", pin_out, '0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 and R2: all pins pass straight through after reset
    pin_in = 8'h5A; #1 chk("R1 reset unfiltered", pin_out, 8'h5A);
    pin_in = 8'hC3; #1 chk("R2 no latency", pin_out, 8'hC3);
    pin_in = '0;
    cyc(1);
    // configure: mode before enable
    sel_long = DBM; cyc(1); sel_long = '0;
    flt_on = GLM | DBM; cyc(1); flt_on = '0;
    chk("R9 enable on steady low", pin_out, '0);

    for (int d = 0; d < 4; d++) hold_test(CW'(d), d);
    hold_test(8'hF1, 1); // R8: upper bits ignored, D=1

    for (int d = 0; d < 3; d++)
      for (int w = 1; w <= 2 * 2 * (d + 1) + 1; w++)
        pulse_test(d, w);

    // R3: simultaneous on/off on pin2, plain off on pin3
    cyc(2);
    flt_on = 8'h04; flt_off = 8'h0C; cyc(1); flt_on = '0; flt_off = '0;
    pin_in = 8'h0C; #1 chk("R3 off wins / masked clear", pin_out, 8'h0C);
    pin_in = '0; cyc(4);
    // R4: both mode masks on pins 4,5 -> short; pin2 goes long, pin3 stays short
    sel_long = 8'h34; sel_short = 8'h30; cyc(1); sel_long = '0; sel_short = '0;
    flt_on = 8'h0C; cyc(1); flt_on = '0;
    wr_div(CW'(3));
    pin_in = '1;
    cyc(2); chk("R4 short wins, others kept", pin_out, DISM | 8'h38);
    cyc(13); chk("R4 long pins before 2nd tick", pin_out, DISM | 8'h38);
    cyc(1); chk("R4 long pins at 2nd tick", pin_out, '1);
    // R9: enable pin0 while its input is steady high
    flt_on = 8'h01; cyc(1); flt_on = '0;
    chk("R9 enable on steady high", pin_out, '1);
    cyc(3); chk("R9 still steady", pin_out, '1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule